// File: doc/BRIEF.md
# Reset and Boot-Mode Latch Controller

This block turns an asynchronous active-low reset pin and a watchdog reset request into one synchronous system reset in the slow-clock domain. When the pin reset is released, it captures the configuration pins: the boot-mode selection, the tri-state request and the two debug-mode selection pins. Those captured values then stay fixed until the next pin reset. A watchdog reset restarts the system but keeps the configuration already captured.

The tri-state request is active low. It is honoured only if the pin was low on every one of the final slow-clock edges of the reset pulse. When tri-state mode is captured, the block drives its output-enable mask to all zeros, so a probe can take over the board's pins while the logic behind them keeps running. The debug-mode pins matter only at the release of a pin reset. In-circuit emulation is selected when the second debug pin is captured low.

Top module: `rstboot_ctrl`

## Requirements
- R1: With the default two-stage synchronizer, `sys_rst_n` goes low on the third rising edge of `clk_slow` on which `ext_rst_n` has been seen low. After `ext_rst_n` rises, `sys_rst_n` stays low through the third rising edge on which the pin is seen high and goes high on the fourth: two synchronizer stages plus one extra cycle.
- R2: `tristate_q` is captured as 1 only if `tri_req_n` was 0 on each of the last `WIN_LEN` (10) edges before the edge on which `ext_rst_n` is first seen high. If `tri_req_n` was 1 on any of those edges, it is captured as 0.
- R3: If the pin reset lasts fewer than `WIN_LEN` edges, `tristate_q` is captured as 0 whatever `tri_req_n` does.
- R4: A `wdog_req` high on one edge, with no reset in progress, makes `sys_rst_n` low from that edge for exactly `WD_LEN` (4) cycles. The captured `tristate_q`, `boot_mode_q` and `dbg_mode_q` keep their values whatever the pins do meanwhile.
- R5: A `wdog_req` that arrives while a watchdog reset is already running is ignored; the reset is not lengthened.
- R6: The pin reset has priority. A watchdog request made during a pin reset is dropped. The release timing of R1 holds, and the pins are captured as for any pin reset.
- R7: `oe_mask` is all zeros while `tristate_q` is 1 and all ones while it is 0.
- R8: `boot_mode_q` and `dbg_mode_q` take the levels of `boot_pin` and `dbg_pin` on the edge where `ext_rst_n` is first seen high. Later changes on those pins have no effect. `ice_sel` is 1 exactly when `dbg_mode_q[1]` is 0.
- R9: From the third edge of a pin reset until its release, the captured modes read as normal: `tristate_q`=0, `boot_mode_q`=0 and `dbg_mode_q`=00. This also makes them the power-up defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow clock |
| ext_rst_n | input | 1 | External reset pin, asynchronous, active low |
| wdog_req | input | 1 | Watchdog reset request, synchronous to `clk_slow` |
| tri_req_n | input | 1 | Tri-state request pin, active low |
| boot_pin | input | 1 | Boot-mode selection pin |
| dbg_pin | input | 2 | Debug-mode selection pins |
| sys_rst_n | output | 1 | System reset, active low |
| tristate_q | output | 1 | Captured tri-state mode |
| boot_mode_q | output | 1 | Captured boot mode |
| dbg_mode_q | output | 2 | Captured debug-mode pins |
| ice_sel | output | 1 | In-circuit emulation selected |
| oe_mask | output | N_OE | Output-enable mask, all zeros in tri-state mode |

## Verification
The hardest case to reach from the ports is the edge of the tri-state window. Capture must succeed when the single high sample falls one edge before the window, and fail when it falls on the window's first edge or when the reset is one edge too short. Directed pin resets of length 9, 10 and 15 place that high sample precisely, and random lengths and patterns cover the rest. A further hard case is a watchdog request that lands inside a pin reset. Requests are placed both on the pulse's first edge, while the synchronized pin still reads high, and deep inside it. Each such case then checks that the release still follows the pin timing exactly.

// File: rtl/rstboot_pkg.sv
// Shared types for the reset and boot-mode latch controller.
package rstboot_pkg;
    // Configuration captured at the release of a pin reset.
    typedef struct packed {
        logic       tri_on;
        logic       boot;
        logic [1:0] dbg;
    } cfg_t;
endpackage

// File: rtl/rstboot_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes every bit is an independent level signal; no reset, the
// chain is flushed by the pins themselves within STAGES cycles.
module rstboot_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the pin levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        stg[0] <= d;
        for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rstboot_win.sv
// Counts consecutive low samples of the synchronized tri-state
// request while the synchronized pin reset is asserted; saturates at
// WIN. Assumes hold_n and req_n are aligned by equal-depth synchronizers.
module rstboot_win #(
    parameter int WIN = 10
) (
    input  logic clk,
    input  logic hold_n,
    input  logic req_n,
    output logic full
);
    localparam int CW = $clog2(WIN + 1);
    logic [CW-1:0] cnt;

    // Consecutive-low counter, cleared outside reset or on a high sample.
    always_ff @(posedge clk) begin
        if (hold_n || req_n) cnt <= '0;
        else if (cnt != CW'(WIN)) cnt <= cnt + 1'b1;
    end

    assign full = (cnt == CW'(WIN));
endmodule

// File: rtl/rstboot_wdstretch.sv
// Stretches a one-cycle watchdog request into a LEN-cycle reset hold.
// Synchronous active-low reset (the synchronized pin reset) cancels it,
// which gives the pin reset priority. Requests while busy are dropped.
module rstboot_wdstretch #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic hold_nxt
);
    localparam int CW = $clog2(LEN + 1);
    logic [CW-1:0] cnt, cnt_nxt;

    // Next-count: decrement while busy, load on an idle request.
    always_comb begin
        if (!rst_n)          cnt_nxt = '0;
        else if (cnt != '0)  cnt_nxt = cnt - 1'b1;
        else if (req)        cnt_nxt = CW'(LEN);
        else                 cnt_nxt = '0;
    end

    // Count register.
    always_ff @(posedge clk) cnt <= cnt_nxt;

    assign hold_nxt = (cnt_nxt != '0);

    // R5: a running stretch counts down regardless of new requests.
    p_no_retrigger_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> (cnt == CW'($past(cnt) - 1'b1)));
endmodule

// File: rtl/rstboot_ctrl.sv
// Reset and boot-mode latch controller (top).
// Merges the pin reset and the watchdog request into sys_rst_n,
// captures boot, tri-state and debug pins on pin-reset release, and
// masks all output enables in tri-state mode. Assumes wdog_req is
// synchronous to clk_slow and the other pins are asynchronous levels.
module rstboot_ctrl #(
    parameter int WIN_LEN     = 10,
    parameter int WD_LEN      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int N_OE        = 32
) (
    input  logic            clk_slow,
    input  logic            ext_rst_n,
    input  logic            wdog_req,
    input  logic            tri_req_n,
    input  logic            boot_pin,
    input  logic [1:0]      dbg_pin,
    output logic            sys_rst_n,
    output logic            tristate_q,
    output logic            boot_mode_q,
    output logic [1:0]      dbg_mode_q,
    output logic            ice_sel,
    output logic [N_OE-1:0] oe_mask
);
    import rstboot_pkg::*;

    localparam int NPIN = 5;

    logic [NPIN-1:0] pins_s;
    logic            ext_s, tri_s, boot_s;
    logic [1:0]      dbg_s;
    logic            ext_d, rel, win_full, wd_hold_nxt, sys_q;
    cfg_t            cfg_q;

    rstboot_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk_slow),
        .d   ({ext_rst_n, tri_req_n, boot_pin, dbg_pin}),
        .q   (pins_s)
    );
    assign {ext_s, tri_s, boot_s, dbg_s} = pins_s;

    rstboot_win #(.WIN(WIN_LEN)) u_win (
        .clk    (clk_slow),
        .hold_n (ext_s),
        .req_n  (tri_s),
        .full   (win_full)
    );

    rstboot_wdstretch #(.LEN(WD_LEN)) u_wd (
        .clk      (clk_slow),
        .rst_n    (ext_s),
        .req      (wdog_req),
        .hold_nxt (wd_hold_nxt)
    );

    // Delayed synchronized pin level for release detection.
    always_ff @(posedge clk_slow) ext_d <= ext_s;
    assign rel = ext_s & ~ext_d;

    // System reset: pin reset plus one extra cycle, or watchdog hold.
    always_ff @(posedge clk_slow) sys_q <= ext_s & ext_d & ~wd_hold_nxt;

    // Configuration capture: normal defaults during pin reset, load at release.
    always_ff @(posedge clk_slow) begin
        if (!ext_s)   cfg_q <= '0;
        else if (rel) cfg_q <= '{tri_on: win_full, boot: boot_s, dbg: dbg_s};
    end

    assign sys_rst_n   = sys_q;
    assign tristate_q  = cfg_q.tri_on;
    assign boot_mode_q = cfg_q.boot;
    assign dbg_mode_q  = cfg_q.dbg;
    assign ice_sel     = ~cfg_q.dbg[1];
    assign oe_mask     = cfg_q.tri_on ? '0 : '1;

    // R1: a synchronized pin reset always holds the system reset.
    p_rst_hold_r1: assert property (@(posedge clk_slow) disable iff ($isunknown(ext_d))
        !ext_s |=> !sys_rst_n);

    // R1: the system reset only releases after two high synchronized samples.
    p_rel_delay_r1: assert property (@(posedge clk_slow) disable iff ($isunknown(ext_d))
        $rose(sys_rst_n) |-> ($past(ext_s, 1) && $past(ext_s, 2)));

    // R2: tri-state mode can only switch on at a pin-reset release.
    p_tri_at_rel_r2: assert property (@(posedge clk_slow) disable iff ($isunknown(ext_d))
        $rose(cfg_q.tri_on) |-> $past(rel));

    // R4/R8: outside pin-reset edges the captured configuration is frozen.
    p_cfg_frozen_r4: assert property (@(posedge clk_slow) disable iff ($isunknown(ext_d))
        (ext_s && $past(ext_s) && $past(ext_s, 2)) |-> $stable(cfg_q));
endmodule

// File: tb/rstboot_ctrl_tb.sv
module rstboot_ctrl_tb_top;
    localparam int N_OE = 32;

    logic            clk = 1'b0;
    logic            ext_rst_n = 1'b0, wdog_req = 1'b0, tri_req_n = 1'b1, boot_pin = 1'b0;
    logic [1:0]      dbg_pin = 2'b00;
    logic            sys_rst_n, tristate_q, boot_mode_q, ice_sel;
    logic [1:0]      dbg_mode_q;
    logic [N_OE-1:0] oe_mask;

    int n_tests = 0, n_fail = 0;
    logic       e_tri = 1'b0, e_boot = 1'b0;
    logic [1:0] e_dbg = 2'b00;

    rstboot_ctrl #(.N_OE(N_OE)) dut_i (
        .clk_slow(clk), .ext_rst_n(ext_rst_n), .wdog_req(wdog_req),
        .tri_req_n(tri_req_n), .boot_pin(boot_pin), .dbg_pin(dbg_pin),
        .sys_rst_n(sys_rst_n), .tristate_q(tristate_q), .boot_mode_q(boot_mode_q),
        .dbg_mode_q(dbg_mode_q), .ice_sel(ice_sel), .oe_mask(oe_mask)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic exp_tri(input int len, input logic [31:0] tb);
        if (len < 10) return 1'b0;
        for (int i = len - 10; i < len; i++) if (tb[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk_cfg(input string req);
        chk(tristate_q == e_tri, req, "tristate_q", tristate_q, e_tri);
        chk(boot_mode_q == e_boot, req, "boot_mode_q", boot_mode_q, e_boot);
        chk(dbg_mode_q == e_dbg, req, "dbg_mode_q", dbg_mode_q, e_dbg);
        chk(ice_sel == ~e_dbg[1], "R8", "ice_sel", ice_sel, ~e_dbg[1]);
        chk(oe_mask == (e_tri ? '0 : '1), "R7", "oe_mask", oe_mask, e_tri ? 0 : 32'hFFFF_FFFF);
    endtask

    // Pin reset of len cycles; tb bit i is tri_req_n in cycle i; wd_at < 0 means no watchdog.
    task automatic do_ext(input int len, input logic [31:0] tb, input logic bt,
                          input logic [1:0] dm, input int wd_at);
        boot_pin = bt;
        dbg_pin  = dm;
        for (int i = 0; i < len; i++) begin
            ext_rst_n = 1'b0;
            tri_req_n = tb[i];
            wdog_req  = (i == wd_at);
            tick();
        end
        wdog_req = 1'b0;
        if (len >= 3) begin
            chk(sys_rst_n == 1'b0, "R1", "sys_rst_n held", sys_rst_n, 0);
            chk(tristate_q == 1'b0 && boot_mode_q == 1'b0 && dbg_mode_q == 2'b00,
                "R9", "defaults during reset", {tristate_q, boot_mode_q, dbg_mode_q}, 0);
        end
        ext_rst_n = 1'b1;
        tri_req_n = 1'($urandom);
        e_tri  = exp_tri(len, tb);
        e_boot = bt;
        e_dbg  = dm;
        tick(); tick(); tick();
        chk(sys_rst_n == 1'b0, "R1", "sys_rst_n third edge", sys_rst_n, 0);
        chk_cfg(len < 10 ? "R3" : "R2");
        tick();
        chk(sys_rst_n == 1'b1, wd_at >= 0 ? "R6" : "R1", "sys_rst_n release", sys_rst_n, 1);
        boot_pin  = ~bt;
        dbg_pin   = ~dm;
        tri_req_n = 1'b0;
        tick(); tick(); tick();
        chk_cfg("R8");
    endtask

    // Watchdog pulse, optionally re-requested while running; pins scrambled meanwhile.
    task automatic do_wd(input bit retrig);
        wdog_req  = 1'b1;
        boot_pin  = 1'($urandom);
        dbg_pin   = 2'($urandom);
        tri_req_n = 1'($urandom);
        tick();
        wdog_req = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            chk(sys_rst_n == (k >= 5), retrig ? "R5" : "R4", "watchdog hold",
                sys_rst_n, (k >= 5));
            wdog_req = (retrig && k == 2);
            tick();
        end
        wdog_req = 1'b0;
        chk_cfg("R4");
    endtask

    initial begin
        void'($urandom(32'h0000_5EED));
        // Power-up reset: defaults, then tri request high -> normal.
        do_ext(12, 32'hFFFF_FFFF, 1'b0, 2'b00, -1);
        chk(oe_mask == '1, "R7", "oe_mask normal", oe_mask, 32'hFFFF_FFFF);
        // R2: exactly 10 low cycles enters tri-state.
        do_ext(10, 32'h0, 1'b1, 2'b01, -1);
        do_wd(1'b0);
        do_wd(1'b1);
        // R3: 9 cycles too short.
        do_ext(9, 32'h0, 1'b0, 2'b10, -1);
        // R2: high sample on the first window edge -> normal; one before -> tri-state.
        do_ext(15, 32'h1 << 5, 1'b1, 2'b11, -1);
        do_ext(15, 32'h1 << 4, 1'b1, 2'b00, -1);
        // R6: watchdog on first edge and in the middle of a pin reset.
        do_ext(12, 32'h0, 1'b0, 2'b01, 0);
        do_ext(20, 32'h0, 1'b1, 2'b10, 8);
        do_wd(1'b1);
        // Random mix.
        for (int it = 0; it < 60; it++) begin
            int len, wd, mode;
            logic [31:0] tb;
            len  = 1 + int'($urandom % 24);
            mode = int'($urandom % 4);
            tb   = (mode == 0) ? 32'h0 : (mode == 1) ? (32'h1 << ($urandom % 32)) : $urandom;
            wd   = ($urandom % 3 == 0) ? int'($urandom % len) : -1;
            do_ext(len, tb, 1'($urandom), 2'($urandom), wd);
            if ($urandom % 2 == 1) do_wd(1'($urandom));
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule